// File: doc/BRIEF.md
# Configuration and Reset Sequencer

This controller brings a programmable device up from a raw bitstream and decides when the user logic inside it may leave reset. After a board reset or a request from the configuration switch, it pulses the device's program line low. It then waits for the device to report that it is ready. Next it streams bytes into a byte-wide slave parallel configuration port, each byte with its own write strobe and chip select. Those bytes come either from a shared byte link or from an on-board flash that is read from address zero upward.

Once the device reports done, the sequencer watches the link for a 32-bit end key. Only that key releases the user reset. From then on the link belongs to the user design and the sequencer no longer consumes it. It still listens passively for a 32-bit start key, which pulls the user reset low again and restarts the whole sequence. If a flash load runs out of bytes and the done flag never comes, an error flag latches and the user design stays in reset.

Top module: `cfg_reset_seq`

## Requirements
- R1: When `rst_n` is low at a clock edge, the next cycle shows `user_rst_n`=0, `dev_prog_n`=1, `dev_wr_n`=`dev_cs_n`=1, `cfg_err`=0 and `link_own`=1. `user_rst_n` then stays low until the end key completes.
- R2: `cfg_req_n` low at a clock edge has exactly the same effect as `rst_n` low.
- R3: In the second cycle after reset is released, `dev_prog_n` goes low. It stays low for exactly `PROG_CYC` cycles.
- R4: After the program pulse, nothing is written to the device until `dev_init` is high. Link bytes arriving before then are neither written nor matched. `src_flash` (1 = flash, 0 = link) is sampled in the cycle where `dev_init` is seen high.
- R5: In link mode, a byte accepted while loading (`link_valid`=1) appears on `dev_data` in the next cycle, with `dev_wr_n` and `dev_cs_n` both low for that one cycle. A byte offered in a cycle where `dev_done` is high is not written.
- R6: In flash mode, `flash_rd` is asserted one cycle per byte, with `flash_addr` stepping 0, 1, 2, and so on. The byte on `flash_data` in the cycle after a read is written to the device one cycle later. Reading stops once `dev_done` rises or `FLASH_BYTES` reads have been issued.
- R7: After the last flash read, if `dev_done` stays low for `DONE_TMO` cycles, `cfg_err` rises. It stays high until reset. While it is high, `user_rst_n` stays low even if the end key arrives.
- R8: After `dev_done`, `user_rst_n` rises in the cycle after four consecutive accepted link bytes equal `END_KEY`, least significant byte first. A mismatching byte restarts the comparison, and it counts as a new first byte if it equals the key's low byte.
- R9: While `user_rst_n` is high, `link_own` is low and no device write strobe occurs.
- R10: A complete `START_KEY` (same byte order) accepted after `dev_done`, whether or not the user reset is released, drives `user_rst_n` low in the next cycle. The program pulse then follows as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Board reset, synchronous, active low |
| cfg_req_n | input | 1 | Configuration-request switch, active low, restarts the sequence |
| src_flash | input | 1 | Source select: 1 = flash, 0 = link |
| link_valid | input | 1 | A link byte is present this cycle |
| link_data | input | 8 | Link byte |
| link_own | output | 1 | High while the sequencer owns the shared link |
| flash_rd | output | 1 | Flash read request |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_data | input | 8 | Flash byte, valid the cycle after a read |
| dev_prog_n | output | 1 | Device program line, active low |
| dev_init | input | 1 | Device ready-for-data flag |
| dev_cs_n | output | 1 | Configuration port chip select, active low |
| dev_wr_n | output | 1 | Configuration port write strobe, active low |
| dev_data | output | 8 | Configuration byte |
| dev_done | input | 1 | Device configured flag |
| user_rst_n | output | 1 | Reset of the user design, active low |
| cfg_err | output | 1 | Done timeout after a flash load |

## Verification
The hardest state to reach is the latched error. It needs a flash load that runs through all of its byte reads, followed by a done flag held low for the full timeout window. The bench reaches it by restarting through the request switch with flash mode selected and `dev_done` kept low. It then sends a valid end key to show the reset stays low. Key matching around a false start is also exercised: the sequence low byte, second byte, low byte again, then the remaining bytes must still release. Start keys are sent both before and after release.

// File: rtl/cfg_seq_pkg.sv
// Shared types for the configuration and reset sequencer.
package cfg_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE_RST,
        ST_PROG,
        ST_WAIT_INIT,
        ST_LOAD,
        ST_WAIT_DONE,
        ST_WAIT_KEY,
        ST_RUN
    } seq_state_t;
endpackage

// File: rtl/cfg_key_match.sv
// Four-byte key detector on a byte stream, least significant byte first.
// Assumes the four key bytes are distinct, so a restart that checks only the
// low byte finds every occurrence. Progress is cleared while en is low.
module cfg_key_match #(
    parameter logic [31:0] KEY = 32'h0
) (
    input  logic       clk,
    input  logic       srst_n,
    input  logic       en,
    input  logic       valid,
    input  logic [7:0] data,
    output logic       match
);
    logic [1:0] idx;
    logic       hit;

    assign hit   = (data == KEY[{idx, 3'b000} +: 8]);
    assign match = en && valid && hit && (idx == 2'd3);

    // Advance on each matching byte, restart on a mismatch.
    always_ff @(posedge clk) begin
        if (!srst_n || !en) begin
            idx <= '0;
        end else if (valid) begin
            if (hit)
                idx <= idx + 2'd1;
            else
                idx <= (data == KEY[7:0]) ? 2'd1 : 2'd0;
        end
    end
endmodule

// File: rtl/cfg_write_port.sv
// Drives the slave parallel configuration port. A link byte is written the
// cycle after it is accepted. A flash byte is written the cycle after it
// returns, which is two cycles after its read request.
module cfg_write_port (
    input  logic       clk,
    input  logic       srst_n,
    input  logic       link_wr,
    input  logic [7:0] link_data,
    input  logic       flash_rd,
    input  logic [7:0] flash_data,
    output logic [7:0] dev_data,
    output logic       dev_wr_n,
    output logic       dev_cs_n
);
    logic rd_q;

    // Track which flash reads have data arriving this cycle.
    always_ff @(posedge clk) begin
        if (!srst_n) rd_q <= 1'b0;
        else         rd_q <= flash_rd;
    end

    // Register one byte and one strobe per write.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            dev_data <= '0;
            dev_wr_n <= 1'b1;
            dev_cs_n <= 1'b1;
        end else if (link_wr) begin
            dev_data <= link_data;
            dev_wr_n <= 1'b0;
            dev_cs_n <= 1'b0;
        end else if (rd_q) begin
            dev_data <= flash_data;
            dev_wr_n <= 1'b0;
            dev_cs_n <= 1'b0;
        end else begin
            dev_wr_n <= 1'b1;
            dev_cs_n <= 1'b1;
        end
    end

    // R5
    strobe_source_chk: assert property (@(posedge clk) disable iff (!srst_n)
        !dev_wr_n |-> ($past(link_wr) || $past(rd_q)));
endmodule

// File: rtl/cfg_reset_seq.sv
// Configuration and reset sequencer top. Pulses program, waits for init,
// loads bytes from the link or the flash, waits for done, then releases the
// user reset on the end key. A start key after done restarts the sequence.
// Assumes every input is synchronous to clk.
module cfg_reset_seq
    import cfg_seq_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          PROG_CYC    = 4,
    parameter int          FLASH_BYTES = 16,
    parameter int          DONE_TMO    = 20,
    parameter logic [31:0] START_KEY   = 32'hC3A5_5A3C,
    parameter logic [31:0] END_KEY     = 32'h5EED_C0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req_n,
    input  logic              src_flash,
    input  logic              link_valid,
    input  logic [7:0]        link_data,
    output logic              link_own,
    output logic              flash_rd,
    output logic [ADDR_W-1:0] flash_addr,
    input  logic [7:0]        flash_data,
    output logic              dev_prog_n,
    input  logic              dev_init,
    output logic              dev_cs_n,
    output logic              dev_wr_n,
    output logic [7:0]        dev_data,
    input  logic              dev_done,
    output logic              user_rst_n,
    output logic              cfg_err
);
    localparam int                CNT_MAX   = (PROG_CYC > DONE_TMO) ? PROG_CYC : DONE_TMO;
    localparam int                CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0]  PROG_LAST = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0]  TMO_LAST  = CNT_W'(DONE_TMO - 1);
    localparam logic [ADDR_W:0]   FL_LIMIT  = (ADDR_W + 1)'(FLASH_BYTES);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [ADDR_W:0]  addr_q;
    logic             src_q;
    logic             srst_n;
    logic             link_wr;
    logic             end_hit;
    logic             start_hit;
    logic             end_en;
    logic             start_en;

    assign srst_n     = rst_n && cfg_req_n;
    assign user_rst_n = (state == ST_RUN);
    assign link_own   = (state != ST_RUN);
    assign dev_prog_n = (state != ST_PROG);
    assign flash_addr = addr_q[ADDR_W-1:0];
    assign flash_rd   = (state == ST_LOAD) && src_q && !dev_done && (addr_q < FL_LIMIT);
    assign link_wr    = (state == ST_LOAD) && !src_q && !dev_done && link_valid;
    assign end_en     = (state == ST_WAIT_KEY);
    assign start_en   = (state == ST_WAIT_KEY) || (state == ST_RUN);

    cfg_key_match #(.KEY(END_KEY)) u_end_key (
        .clk(clk), .srst_n(srst_n), .en(end_en), .valid(link_valid),
        .data(link_data), .match(end_hit)
    );

    cfg_key_match #(.KEY(START_KEY)) u_start_key (
        .clk(clk), .srst_n(srst_n), .en(start_en), .valid(link_valid),
        .data(link_data), .match(start_hit)
    );

    cfg_write_port u_wport (
        .clk(clk), .srst_n(srst_n), .link_wr(link_wr), .link_data(link_data),
        .flash_rd(flash_rd), .flash_data(flash_data),
        .dev_data(dev_data), .dev_wr_n(dev_wr_n), .dev_cs_n(dev_cs_n)
    );

    // Sequence state, shared counter, flash address and error flag.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            state   <= ST_IDLE_RST;
            cnt     <= '0;
            addr_q  <= '0;
            src_q   <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE_RST: begin
                    state <= ST_PROG;
                    cnt   <= '0;
                end
                ST_PROG: begin
                    if (cnt == PROG_LAST) begin
                        state <= ST_WAIT_INIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT_INIT: begin
                    if (dev_init) begin
                        state  <= ST_LOAD;
                        src_q  <= src_flash;
                        addr_q <= '0;
                    end
                end
                ST_LOAD: begin
                    if (dev_done) begin
                        state <= ST_WAIT_KEY;
                    end else if (src_q && addr_q == FL_LIMIT) begin
                        state <= ST_WAIT_DONE;
                        cnt   <= '0;
                    end else if (flash_rd) begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_WAIT_DONE: begin
                    if (!cfg_err) begin
                        if (dev_done)             state   <= ST_WAIT_KEY;
                        else if (cnt == TMO_LAST) cfg_err <= 1'b1;
                        else                      cnt     <= cnt + 1'b1;
                    end
                end
                ST_WAIT_KEY: begin
                    if (end_hit)        state <= ST_RUN;
                    else if (start_hit) state <= ST_IDLE_RST;
                end
                ST_RUN: begin
                    if (start_hit) state <= ST_IDLE_RST;
                end
                default: state <= ST_IDLE_RST;
            endcase
        end
    end

    // R8
    release_on_byte_chk: assert property (@(posedge clk) disable iff (!srst_n)
        $rose(user_rst_n) |-> $past(link_valid));
    // R9
    link_handoff_chk: assert property (@(posedge clk) disable iff (!srst_n)
        !link_own |-> (dev_wr_n && dev_prog_n));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
        cfg_err |=> cfg_err);
    // R7
    err_holds_rst_chk: assert property (@(posedge clk) disable iff (!srst_n)
        cfg_err |-> !user_rst_n);
    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
        (flash_rd && $past(flash_rd)) |-> (flash_addr == $past(flash_addr) + 1'b1));
endmodule

// File: tb/cfg_reset_seq_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed
// checks at scenario points.
module cfg_reset_seq_tb;
    localparam int          AW   = 16;
    localparam int          PC   = 4;
    localparam int          FB   = 16;
    localparam int          TMO  = 20;
    localparam logic [31:0] SKEY = 32'hC3A5_5A3C;
    localparam logic [31:0] EKEY = 32'h5EED_C0DE;

    localparam int P_IDLE = 0, P_PROG = 1, P_INIT = 2, P_LOAD = 3,
                   P_DONE = 4, P_KEY = 5, P_RUN = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, cfg_req_n = 1'b1, src_flash = 1'b0;
    logic          link_valid = 1'b0;
    logic [7:0]    link_data = '0;
    logic          link_own, flash_rd;
    logic [AW-1:0] flash_addr;
    logic [7:0]    flash_data = '0;
    logic [7:0]    fl_pend = '0;
    logic          dev_prog_n, dev_cs_n, dev_wr_n, user_rst_n, cfg_err;
    logic          dev_init = 1'b0, dev_done = 1'b0;
    logic [7:0]    dev_data;

    int checks = 0;
    int errors = 0;

    cfg_reset_seq #(.ADDR_W(AW), .PROG_CYC(PC), .FLASH_BYTES(FB), .DONE_TMO(TMO),
                    .START_KEY(SKEY), .END_KEY(EKEY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_req_n(cfg_req_n), .src_flash(src_flash),
        .link_valid(link_valid), .link_data(link_data), .link_own(link_own),
        .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_data(flash_data),
        .dev_prog_n(dev_prog_n), .dev_init(dev_init), .dev_cs_n(dev_cs_n),
        .dev_wr_n(dev_wr_n), .dev_data(dev_data), .dev_done(dev_done),
        .user_rst_n(user_rst_n), .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash model: data for a read appears the following cycle.
    always @(negedge clk) begin
        flash_data <= fl_pend;
        if (flash_rd) fl_pend <= 8'(flash_addr * 7 + 3);
    end

    // Reference model state.
    int          m_ph = P_IDLE, m_cnt = 0, m_addr = 0;
    logic        m_src = 1'b0, m_rdq = 1'b0, m_wrn = 1'b1, m_err = 1'b0;
    logic [7:0]  m_dat = '0;
    logic [31:0] e_win = '0, s_win = '0;
    int          e_cnt = 0, s_cnt = 0;
    logic        t_frd, t_lwr, t_em, t_sm;

    always @(posedge clk) begin
        if (!rst_n || !cfg_req_n) begin
            m_ph = P_IDLE; m_cnt = 0; m_addr = 0; m_src = 0; m_rdq = 0;
            m_wrn = 1; m_err = 0; m_dat = '0; e_cnt = 0; s_cnt = 0;
        end else begin
            t_frd = (m_ph == P_LOAD) && m_src && !dev_done && (m_addr < FB);
            t_lwr = (m_ph == P_LOAD) && !m_src && !dev_done && link_valid;
            if (t_lwr) begin m_dat = link_data; m_wrn = 0; end
            else if (m_rdq) begin m_dat = flash_data; m_wrn = 0; end
            else m_wrn = 1;
            m_rdq = t_frd;
            t_em = 0; t_sm = 0;
            if (m_ph == P_KEY) begin
                if (link_valid) begin
                    e_win = {link_data, e_win[31:8]};
                    if (e_cnt < 4) e_cnt++;
                    if (e_cnt == 4 && e_win == EKEY) begin t_em = 1; e_cnt = 0; end
                end
            end else e_cnt = 0;
            if (m_ph == P_KEY || m_ph == P_RUN) begin
                if (link_valid) begin
                    s_win = {link_data, s_win[31:8]};
                    if (s_cnt < 4) s_cnt++;
                    if (s_cnt == 4 && s_win == SKEY) begin t_sm = 1; s_cnt = 0; end
                end
            end else s_cnt = 0;
            case (m_ph)
                P_IDLE: begin m_ph = P_PROG; m_cnt = 0; end
                P_PROG: if (m_cnt == PC - 1) begin m_ph = P_INIT; m_cnt = 0; end
                        else m_cnt++;
                P_INIT: if (dev_init) begin m_ph = P_LOAD; m_src = src_flash; m_addr = 0; end
                P_LOAD: if (dev_done) m_ph = P_KEY;
                        else if (m_src && m_addr == FB) begin m_ph = P_DONE; m_cnt = 0; end
                        else if (t_frd) m_addr++;
                P_DONE: if (!m_err) begin
                            if (dev_done) m_ph = P_KEY;
                            else if (m_cnt == TMO - 1) m_err = 1;
                            else m_cnt++;
                        end
                P_KEY:  if (t_em) m_ph = P_RUN; else if (t_sm) m_ph = P_IDLE;
                P_RUN:  if (t_sm) m_ph = P_IDLE;
                default: m_ph = P_IDLE;
            endcase
        end
        #1;
        check("R8", "user_rst_n", user_rst_n, m_ph == P_RUN);
        check("R3", "dev_prog_n", dev_prog_n, m_ph != P_PROG);
        check("R9", "link_own", link_own, m_ph != P_RUN);
        check("R6", "flash_rd", flash_rd,
              (m_ph == P_LOAD) && m_src && !dev_done && (m_addr < FB));
        check("R6", "flash_addr", flash_addr, m_addr);
        check("R5", "dev_wr_n", dev_wr_n, m_wrn);
        check("R5", "dev_cs_n", dev_cs_n, m_wrn);
        if (!m_wrn) check("R5", "dev_data", dev_data, m_dat);
        check("R7", "cfg_err", cfg_err, m_err);
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        link_valid = 1'b1; link_data = b;
        @(negedge clk);
        link_valid = 1'b0;
    endtask

    task automatic send_key(logic [31:0] k);
        for (int i = 0; i < 4; i++) send(k[8*i +: 8]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(4);
        // R1: reset state
        check("R1", "user_rst_n", user_rst_n, 0);
        check("R1", "dev_prog_n", dev_prog_n, 1);
        check("R1", "dev_wr_n", dev_wr_n, 1);
        check("R1", "link_own", link_own, 1);
        rst_n = 1'b1;
        idle(8);
        // R4: byte before init is not written
        send(8'h11);
        check("R4", "no write before init", dev_wr_n, 1);
        dev_init = 1'b1;
        send(8'h01); send(8'hDE); idle(1); send(8'hC0); send(8'hED); send(8'h5E); send(8'h07);
        dev_done = 1'b1;
        // R5: byte in the done cycle is dropped
        send(8'h99);
        check("R5", "no write with done", dev_wr_n, 1);
        send(8'hDE); send(8'hC0); send(8'hDE);
        check("R8", "partial key holds reset", user_rst_n, 0);
        send(8'hC0); send(8'hED); send(8'h5E);
        check("R8", "released after end key", user_rst_n, 1);
        dev_done = 1'b0;
        send(8'h12);
        check("R9", "no write while released", dev_wr_n, 1);
        check("R9", "link handed over", link_own, 0);
        src_flash = 1'b1;
        send_key(SKEY);
        check("R10", "start key re-asserts reset", user_rst_n, 0);
        idle(1);
        check("R10", "program pulse after start key", dev_prog_n, 0);
        idle(PC + FB + 8);
        dev_done = 1'b1;
        idle(2);
        send_key(EKEY);
        check("R6", "flash path releases", user_rst_n, 1);
        // R2: config request restarts
        @(negedge clk); cfg_req_n = 1'b0; dev_done = 1'b0;
        idle(2);
        check("R2", "request holds reset", user_rst_n, 0);
        check("R2", "request owns link", link_own, 1);
        cfg_req_n = 1'b1;
        idle(PC + FB + TMO + 10);
        check("R7", "timeout error", cfg_err, 1);
        send_key(EKEY);
        check("R7", "end key ignored after error", user_rst_n, 0);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        check("R1", "reset clears error", cfg_err, 0);
        rst_n = 1'b1;
        idle(PC + 6);
        dev_done = 1'b1;
        idle(3);
        check("R6", "reads stop on done", flash_rd, 0);
        send_key(SKEY);
        check("R10", "start key before release", user_rst_n, 0);
        idle(1);
        check("R10", "restart pulses program", dev_prog_n, 0);
        idle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule